// File: doc/BRIEF.md
# Serial Flash Write-Enable Guard

This block is the command front end on the device side of a serial flash interface. It watches the active-low select, the serial clock and the serial data input, all sampled in the system clock domain. It assembles the first byte of each select-low frame as an instruction code and keeps a single enable flag. Every instruction that changes stored contents must be authorised by that flag.

Two instructions drive the flag. The arm code sets it and the disarm code clears it. Each counts only when the frame holds exactly one byte. The block recognises four instructions that modify contents. When the eighth bit of one of them arrives, the block raises a one-cycle grant pulse if the flag is set, or a one-cycle reject pulse if it is not. The back end reports the end of an authorised operation on a done input, and that clears the flag. Decoding is purely serial, so any host that frames bytes under a low select can use the block unchanged.

Top module: `wel_front_end`

## Requirements
- R1: After synchronous reset, `wel` is 0, and `grant` and `reject` are 0.
- R2: A frame of exactly 8 bits carrying code 0x06, shifted most significant bit first on rising `sck` edges while `cs_n` is low, sets `wel`. `wel` reads 1 after the second clock edge that samples `cs_n` high, and still reads 0 after the first.
- R3: A frame of exactly 8 bits carrying code 0x04 clears `wel` with the same timing.
- R4: A 0x06 or 0x04 frame is discarded when `cs_n` rises after any number of bits other than 8, for example 7 or 9. `wel` then keeps its value.
- R5: When the eighth bit of code 0x02, 0xD8, 0xC7 or 0x01 arrives while `wel` is 1, exactly one one-cycle `grant` pulse follows and no `reject`. `wel` stays 1.
- R6: The same codes with `wel` at 0 give exactly one one-cycle `reject` pulse and no `grant`. `wel` stays 0.
- R7: `done` high clears `wel` at the next clock edge. When it coincides with a 0x06 frame taking effect, the clear wins.
- R8: Any other code (for example 0x9F or 0x05) gives no pulse and leaves `wel` unchanged.
- R9: `grant` and `reject` are never high together, and each frame yields at most one pulse.
- R10: `sck` edges while `cs_n` is high shift nothing. A following well-framed instruction decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, sampled by clk |
| mosi | input | 1 | Serial data input, MSB first |
| done | input | 1 | Back end reports a modifying operation finished |
| wel | output | 1 | Current enable flag |
| grant | output | 1 | One-cycle pulse: modifying code accepted |
| reject | output | 1 | One-cycle pulse: modifying code refused |

## Verification
The bench builds the block with its default 8-bit instruction width. This makes every listed code, including the two flag codes, reachable with real framing. Short and long frames of 7 and 9 bits reach both sides of the exact-byte test. With the default counter width, frames longer than a byte saturate without wrapping back to 8, so a nine-bit frame is a true overrun case.

// File: rtl/wel_pkg.sv
package wel_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_ARM     = 8'h06;
    localparam logic [OP_W-1:0] OPC_DISARM  = 8'h04;
    localparam logic [OP_W-1:0] OPC_PAGE    = 8'h02;
    localparam logic [OP_W-1:0] OPC_SECTOR  = 8'hD8;
    localparam logic [OP_W-1:0] OPC_WHOLE   = 8'hC7;
    localparam logic [OP_W-1:0] OPC_STATUSW = 8'h01;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_ARM    = 2'd1,
        CMD_DISARM = 2'd2,
        CMD_MODIFY = 2'd3
    } cmd_class_e;

    function automatic cmd_class_e classify(input logic [OP_W-1:0] op);
        case (op)
            OPC_ARM:     return CMD_ARM;
            OPC_DISARM:  return CMD_DISARM;
            OPC_PAGE,
            OPC_SECTOR,
            OPC_WHOLE,
            OPC_STATUSW: return CMD_MODIFY;
            default:     return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wel_shifter.sv
module wel_shifter #(
    parameter int OP_W  = 8,
    localparam int CNT_W = $clog2(OP_W + 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    output logic [OP_W-1:0] opcode,
    output logic            byte_stb,
    output logic            frame_ok
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(OP_W);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(OP_W + 1);

    logic             sck_q;
    logic             cs_q;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise = sck && !sck_q && !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            cnt      <= '0;
            opcode   <= '0;
            byte_stb <= 1'b0;
            frame_ok <= 1'b0;
        end else begin
            sck_q    <= sck;
            cs_q     <= cs_n;
            byte_stb <= rise && (cnt == FULL - 1'b1);
            frame_ok <= cs_n && !cs_q && (cnt == FULL);
            if (cs_n) begin
                cnt <= '0;
            end else if (rise) begin
                if (cnt < FULL)
                    opcode <= {opcode[OP_W-2:0], mosi};
                if (cnt != SAT)
                    cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_idle_R10: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cnt == '0));

    assert_stb_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> $past(sck) && !$past(cs_n));

endmodule

// File: rtl/wel_latch.sv
module wel_latch
    import wel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_class_e cls,
    input  logic       byte_stb,
    input  logic       frame_ok,
    input  logic       done,
    output logic       wel,
    output logic       grant,
    output logic       reject
);
    logic wel_q;
    logic arm_now, disarm_now, modify_now;

    assign arm_now    = frame_ok && (cls == CMD_ARM);
    assign disarm_now = frame_ok && (cls == CMD_DISARM);
    assign modify_now = byte_stb && (cls == CMD_MODIFY);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= modify_now && wel_q;
            reject <= modify_now && !wel_q;
            if (done || disarm_now)
                wel_q <= 1'b0;
            else if (arm_now)
                wel_q <= 1'b1;
        end
    end

    assign wel = wel_q;

    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));

    assert_grant_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant);

    assert_grant_armed_R5: assert property (@(posedge clk) disable iff (rst)
        grant |-> $past(wel_q));

    assert_reject_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
        reject |-> !wel_q);

    assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !wel_q);

    assert_set_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel_q) |-> $past(arm_now));

endmodule

// File: rtl/wel_front_end.sv
module wel_front_end
    import wel_pkg::*;
#(
    parameter int OPW = wel_pkg::OP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic done,
    output logic wel,
    output logic grant,
    output logic reject
);
    logic [OPW-1:0] opcode;
    logic           byte_stb;
    logic           frame_ok;
    cmd_class_e     cls;

    wel_shifter #(.OP_W(OPW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .opcode   (opcode),
        .byte_stb (byte_stb),
        .frame_ok (frame_ok)
    );

    assign cls = classify(opcode);

    wel_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .cls      (cls),
        .byte_stb (byte_stb),
        .frame_ok (frame_ok),
        .done     (done),
        .wel      (wel),
        .grant    (grant),
        .reject   (reject)
    );

endmodule

// File: tb/sim_wel_front_end.sv
module sim_wel_front_end;
    logic clk = 1'b0;
    logic rst, cs_n, sck, mosi, done;
    logic wel, grant, reject;
    int   checks = 0, errors = 0;
    int   n_grant = 0, n_reject = 0;
    bit   timed_out = 1'b0;

    always #2 clk = ~clk;

    wel_front_end u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
                      .done(done), .wel(wel), .grant(grant), .reject(reject));

    always @(negedge clk) begin
        if (!rst && grant)  n_grant++;
        if (!rst && reject) n_reject++;
        if (!rst && grant && reject) begin
            checks++; errors++;
            $display("FAIL R9 grant and reject together: actual 1/1 expected not both");
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] code, input int nbits);
        cs_n = 1'b0;
        clocks(2);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? code[7-i] : 1'b0;
            sck  = 1'b0;
            clocks(2);
            sck  = 1'b1;
            clocks(2);
        end
        sck = 1'b0;
        clocks(2);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        clocks(4);
    endtask

    task automatic frame(input logic [7:0] code, input int nbits);
        send_bits(code, nbits);
        end_frame();
    endtask

    task automatic t_reset();
        check("R1 wel after reset", wel, 0);
        check("R1 grant after reset", grant, 0);
        check("R1 reject after reset", reject, 0);
    endtask

    task automatic t_arm_timing();
        send_bits(8'h06, 8);
        cs_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 wel after first edge", wel, 0);
        @(posedge clk); @(negedge clk);
        check("R2 wel after second edge", wel, 1);
        clocks(2);
    endtask

    task automatic t_disarm();
        frame(8'h06, 8);
        send_bits(8'h04, 8);
        cs_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R3 wel still set after first edge", wel, 1);
        @(posedge clk); @(negedge clk);
        check("R3 wel cleared by disarm", wel, 0);
        clocks(2);
    endtask

    task automatic t_bad_length();
        frame(8'h06, 7);
        check("R4 arm with 7 bits", wel, 0);
        frame(8'h06, 9);
        check("R4 arm with 9 bits", wel, 0);
        frame(8'h06, 8);
        frame(8'h04, 9);
        check("R4 disarm with 9 bits", wel, 1);
        frame(8'h04, 7);
        check("R4 disarm with 7 bits", wel, 1);
        frame(8'h04, 8);
    endtask

    task automatic t_modify(input logic [7:0] code, input bit armed);
        int g0, r0;
        if (armed) frame(8'h06, 8); else frame(8'h04, 8);
        g0 = n_grant; r0 = n_reject;
        send_bits(code, 16);
        end_frame();
        if (armed) begin
            check($sformatf("R5 grant count for %02h", code), n_grant - g0, 1);
            check($sformatf("R5 reject count for %02h", code), n_reject - r0, 0);
            check($sformatf("R5 wel kept for %02h", code), wel, 1);
            done = 1'b1; clocks(1); done = 1'b0; clocks(1);
            check($sformatf("R7 done clears after %02h", code), wel, 0);
        end else begin
            check($sformatf("R6 reject count for %02h", code), n_reject - r0, 1);
            check($sformatf("R6 grant count for %02h", code), n_grant - g0, 0);
            check($sformatf("R6 wel kept 0 for %02h", code), wel, 0);
        end
    endtask

    task automatic t_done_race();
        frame(8'h04, 8);
        send_bits(8'h06, 8);
        cs_n = 1'b1;
        @(posedge clk); @(negedge clk);
        done = 1'b1;
        @(posedge clk); @(negedge clk);
        done = 1'b0;
        clocks(2);
        check("R7 done beats arm", wel, 0);
    endtask

    task automatic t_unknown();
        int g0, r0;
        frame(8'h06, 8);
        g0 = n_grant; r0 = n_reject;
        frame(8'h9F, 8);
        frame(8'h05, 8);
        check("R8 unknown keeps wel 1", wel, 1);
        frame(8'h04, 8);
        frame(8'h9F, 8);
        check("R8 unknown keeps wel 0", wel, 0);
        check("R8 no pulses", (n_grant - g0) + (n_reject - r0), 0);
    endtask

    task automatic t_idle_clock();
        cs_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            mosi = 1'b1; sck = 1'b1; clocks(2);
            sck = 1'b0; clocks(2);
        end
        frame(8'h06, 8);
        check("R10 arm after idle clocks", wel, 1);
        frame(8'h04, 8);
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; done = 1'b0;
        clocks(4);
        rst = 1'b0;
        clocks(2);
        t_reset();
        t_arm_timing();
        t_disarm();
        t_bad_length();
        t_modify(8'h02, 1'b1);
        t_modify(8'hD8, 1'b1);
        t_modify(8'hC7, 1'b0);
        t_modify(8'h01, 1'b0);
        t_modify(8'hC7, 1'b1);
        t_modify(8'hD8, 1'b0);
        t_done_race();
        t_unknown();
        t_idle_clock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
        checks++; errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule